// File: doc/BRIEF.md
# Bit and Error Interval Counters with Latched Status

This block keeps two running tallies for a bit error rate measurement: how many received bits have been qualified, and how many of those bits were flagged as wrong. Both tallies are CNT_W bits wide (32 by default). When a latch request arrives, both tallies are copied into holding registers and restarted in the same clock cycle. A processor can then read a matched pair of numbers and compute the error ratio for that interval.

A latch request is the rising edge of the OR of an external latch pin and a latch control bit. A small status word records error events, loss of sync, counter wraps and the live sync state. Each status bit has its own interrupt enable, and the interrupt line is active high. The sticky event bits are cleared by a read strobe. The wrap bits are cleared by the next latch request.

Top module: `ber_stat_core`

## Requirements
- R1: Each cycle with `bit_vld_i` high adds one to the bit tally, which is `CNT_W` bits wide (default 32) and wraps modulo 2^CNT_W.
- R2: The error tally adds one only in cycles where `bit_vld_i` and `err_i` are both high; `err_i` alone has no effect.
- R3: In a cycle where `lat_pin_i | lat_ctl_i` rises from 0 to 1, both tallies are copied to `bit_hold_o`/`err_hold_o` at that clock edge and restart. Holding the OR high, or raising the second source while the first is already high, causes no further latch.
- R4: A qualified bit or error in the latch cycle is not lost. It is excluded from the held value and becomes the first count of the new interval.
- R5: `bit_hold_o` and `err_hold_o` change only at a latch.
- R6: A wrap of the bit tally sets `stat_o[2]`, and a wrap of the error tally sets `stat_o[3]`. Each stays set until the next latch clears it, and a status read leaves it unchanged.
- R7: `stat_o[1]` sets on a qualified error and `stat_o[0]` sets on a 1-to-0 change of `sync_i`. Both are sticky and are cleared by a clock edge with `stat_rd_i` high. An event in the same cycle as the read leaves the bit set.
- R8: `stat_o[4]` shows `sync_i` delayed by one clock and is not sticky.
- R9: `irq_o` is high exactly when some `stat_o[k]` and `irq_mask_i[k]` are both 1; a mask bit of 0 blocks that source.
- R10: After reset, both holding registers, the status word and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | One received bit is qualified this cycle |
| err_i | input | 1 | The qualified bit is in error |
| sync_i | input | 1 | Pattern synchronizer locked |
| lat_pin_i | input | 1 | External latch request |
| lat_ctl_i | input | 1 | Latch request from control register |
| irq_mask_i | input | 5 | Per-status interrupt enable, 1 = enabled |
| stat_rd_i | input | 1 | Status read strobe, clears sticky event bits |
| bit_hold_o | output | CNT_W | Bit tally captured at last latch |
| err_hold_o | output | CNT_W | Error tally captured at last latch |
| stat_o | output | 5 | {sync, err wrap, bit wrap, error seen, sync lost} |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The assertions check every cycle that the holding registers stay steady between latches and that a latch restarts a tally at zero or one. They also check that a wrap leaves a zero tally, that the sticky flags survive until a read or a latch, and that an event beats a simultaneous read. They further check that the sync bit drops when sync is lost and that an all-zero mask keeps the interrupt low. Only the bench scenarios show that the held values equal the true interval totals. These include an increment in the latch cycle, a latch level held high, a second source rising while the first is high, and wraps of the narrowed tallies against their flags.

// File: rtl/ber_stat_pkg.sv
package ber_stat_pkg;
  localparam int ST_W = 5;
  typedef enum int unsigned {
    ST_LOS  = 0,
    ST_ERR  = 1,
    ST_BOVF = 2,
    ST_EOVF = 3,
    ST_SYNC = 4
  } st_idx_e;
endpackage

// File: rtl/ber_latch_edge.sv
module ber_latch_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic ctl_i,
  output logic edge_o
);
  logic lvl_d, lvl_q;

  always_comb begin
    lvl_d  = pin_i | ctl_i;
    edge_o = lvl_d & ~lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  // R3: a held request level produces a single latch
  a_r3_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ber_count_bank.sv
module ber_count_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         latch_i,
  output logic [W-1:0] hold_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_d, cnt_q, hold_d, hold_q;
  logic         cnt_en, hold_en, at_max;

  always_comb begin
    at_max  = &cnt_q;
    cnt_en  = inc_i | latch_i;
    hold_en = latch_i;
    hold_d  = cnt_q;
    if (latch_i) begin
      cnt_d  = W'(inc_i);
      wrap_o = 1'b0;
    end else begin
      cnt_d  = cnt_q + W'(inc_i);
      wrap_o = inc_i & at_max;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  a_r5_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(hold_q));
  a_r4_fresh_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (cnt_q <= W'(1)));
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/ber_stat_reg.sv
module ber_stat_reg
  import ber_stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  input  logic            err_ev_i,
  input  logic            bwrap_i,
  input  logic            ewrap_i,
  input  logic            latch_i,
  input  logic            rd_i,
  input  logic [ST_W-1:0] mask_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic [ST_W-1:0] stat_d, stat_q;
  logic            los_ev;

  always_comb begin
    los_ev          = stat_q[ST_SYNC] & ~sync_i;
    stat_d          = stat_q;
    stat_d[ST_LOS]  = (stat_q[ST_LOS]  & ~rd_i)    | los_ev;
    stat_d[ST_ERR]  = (stat_q[ST_ERR]  & ~rd_i)    | err_ev_i;
    stat_d[ST_BOVF] = (stat_q[ST_BOVF] & ~latch_i) | bwrap_i;
    stat_d[ST_EOVF] = (stat_q[ST_EOVF] & ~latch_i) | ewrap_i;
    stat_d[ST_SYNC] = sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_ERR] && !rd_i) |=> stat_q[ST_ERR]);
  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i |=> stat_q[ST_ERR]);
  a_r6_ovf_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_BOVF] && !latch_i) |=> stat_q[ST_BOVF]);
  a_r8_sync_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> !stat_q[ST_SYNC]);
  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/ber_stat_core.sv
module ber_stat_core
  import ber_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             err_i,
  input  logic             sync_i,
  input  logic             lat_pin_i,
  input  logic             lat_ctl_i,
  input  logic [ST_W-1:0]  irq_mask_i,
  input  logic             stat_rd_i,
  output logic [CNT_W-1:0] bit_hold_o,
  output logic [CNT_W-1:0] err_hold_o,
  output logic [ST_W-1:0]  stat_o,
  output logic             irq_o
);
  logic latch_w, err_ev_w, bwrap_w, ewrap_w;

  assign err_ev_w = bit_vld_i & err_i;

  ber_latch_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (lat_pin_i),
    .ctl_i  (lat_ctl_i),
    .edge_o (latch_w)
  );

  ber_count_bank #(.W(CNT_W)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (bit_vld_i),
    .latch_i (latch_w),
    .hold_o  (bit_hold_o),
    .wrap_o  (bwrap_w)
  );

  ber_count_bank #(.W(CNT_W)) u_errs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (err_ev_w),
    .latch_i (latch_w),
    .hold_o  (err_hold_o),
    .wrap_o  (ewrap_w)
  );

  ber_stat_reg u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .err_ev_i (err_ev_w),
    .bwrap_i  (bwrap_w),
    .ewrap_i  (ewrap_w),
    .latch_i  (latch_w),
    .rd_i     (stat_rd_i),
    .mask_i   (irq_mask_i),
    .stat_o   (stat_o),
    .irq_o    (irq_o)
  );

  // R2: an error wrap needs a qualified error in the same cycle
  a_r2_err_wrap_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ewrap_w |-> bit_vld_i);
endmodule

// File: tb/ber_stat_core_bench.sv
`timescale 1ns/1ps
module ber_stat_core_bench;
  localparam int W = 8;
  localparam longint MSK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, err = 1'b0, syn = 1'b0, lp = 1'b0, lc = 1'b0, rd = 1'b0;
  logic [4:0] mask = 5'd0;
  logic [W-1:0] bh, eh;
  logic [4:0] st;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  longint m_cb, m_ce, m_hb, m_he;
  bit [4:0] m_st;
  bit m_lq;

  always #2.5 clk = ~clk;

  ber_stat_core #(.CNT_W(W)) u_ber_stat_core (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .err_i(err), .sync_i(syn),
    .lat_pin_i(lp), .lat_ctl_i(lc), .irq_mask_i(mask), .stat_rd_i(rd),
    .bit_hold_o(bh), .err_hold_o(eh), .stat_o(st), .irq_o(irq)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq();
    return |(m_st & mask);
  endfunction

  task automatic model_edge();
    bit lvl, edg, ib, ie, bw, ew, los;
    lvl = lp | lc;
    edg = lvl & ~m_lq;
    m_lq = lvl;
    ib = vld;
    ie = vld & err;
    bw = 0; ew = 0;
    if (edg) begin
      m_hb = m_cb; m_he = m_ce; m_cb = ib; m_ce = ie;
    end else begin
      bw = ib && (m_cb == MSK);
      ew = ie && (m_ce == MSK);
      m_cb = (m_cb + ib) & MSK;
      m_ce = (m_ce + ie) & MSK;
    end
    los = m_st[4] & ~syn;
    m_st[0] = (m_st[0] & ~rd) | los;
    m_st[1] = (m_st[1] & ~rd) | ie;
    m_st[2] = (m_st[2] & ~edg) | bw;
    m_st[3] = (m_st[3] & ~edg) | ew;
    m_st[4] = syn;
  endtask

  task automatic compare_all();
    chk("R1 bit_hold", bh, m_hb);
    chk("R2 err_hold", eh, m_he);
    chk("R7 sticky", st[1:0], m_st[1:0]);
    chk("R6 wrap", st[3:2], m_st[3:2]);
    chk("R8 sync", st[4], m_st[4]);
    chk("R9 irq", irq, exp_irq());
  endtask

  task automatic step(bit v, bit e, bit s, bit p, bit c, bit r);
    @(negedge clk);
    vld = v; err = e; syn = s; lp = p; lc = c; rd = r;
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cb = 0; m_ce = 0; m_hb = 0; m_he = 0; m_st = 0; m_lq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 bit_hold", bh, 0);
    chk("R10 err_hold", eh, 0);
    chk("R10 stat", st, 0);
    chk("R10 irq", irq, 0);
    @(negedge clk) rst_n = 1'b1;

    mask = 5'h1f;
    // R2: err without vld ignored; check via latch
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R2 err alone ignored", eh, 0);
    chk("R1 three bits", bh, 3);
    // R3: held high gives no second latch; second source rising while first high
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 1, 0);
    chk("R5 hold kept while level high", bh, 3);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R3 no extra latch", bh, 3);
    // R4: increment in latch cycle goes to new interval
    for (int i = 0; i < 2; i++) step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, 0);
    chk("R4 latch excludes own bit", bh, 7);
    chk("R4 latch excludes own err", eh, 6);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R4 carried into new interval", bh, 1);
    // R7: read with simultaneous event keeps bit
    step(1, 1, 0, 0, 0, 1);
    chk("R7 event beats read", st[1], 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R7 read clears", st[1], 0);
    // R8 and loss of sync
    step(0, 0, 1, 0, 0, 0);
    chk("R8 sync live", st[4], 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R7 sync lost flag", st[0], 1);
    chk("R8 sync drops", st[4], 0);
    // R9: mask zero blocks
    mask = 5'h00;
    step(1, 1, 0, 0, 0, 0);
    chk("R9 masked", irq, 0);
    mask = 5'h02;
    step(0, 0, 0, 0, 0, 0);
    chk("R9 enabled source", irq, 1);
    // R6: long interval to wrap both tallies; read must not clear wrap
    mask = 5'h1f;
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) step(1, 1, 1, 0, 0, i[3]);
    chk("R6 bit wrap set", st[2], 1);
    chk("R6 err wrap set", st[3], 1);
    step(0, 0, 1, 1, 0, 1);
    chk("R6 latch clears wrap", st[3:2], 0);
    // random mix
    for (int i = 0; i < 20000; i++) begin
      int unsigned r;
      bit p, c;
      r = $urandom;
      if (i % 97 == 0) mask = 5'($urandom);
      p = ((r >> 8) % 61) == 0;
      c = ((r >> 14) % 83) == 0;
      step((r % 10) < 7, ((r >> 4) % 10) == 0, ((r >> 20) % 40) != 0,
           p, c, ((r >> 26) % 13) == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule